// File: doc/BRIEF.md
# Serial Paged Flash Command Responder

This block is the device end of a serial flash memory reached over a four-wire SPI link (mode 0). It runs on a system clock `clk` and oversamples the serial clock, chip select and data input. Each transaction opens with a one-byte opcode. Depending on that opcode, a three-byte address follows, then data bytes in or out. The block keeps a write-enable latch and a busy (write-in-progress) flag. It also holds a powered-down state and a small on-chip byte array that stands in for the flash cells.

Program, write and erase jobs are timed by a counter that walks the target page or sector one byte per `clk` cycle. A page job stays busy for 256 cycles. A sector job stays busy for 2^SECT_W cycles. An active-low protect pin makes the lowest `PROT_PAGES` pages read-only. The array holds 2^ADDR_W bytes (default 2048, which is 8 pages of 256 bytes in 2 sectors of 1024 bytes). Address bits at and above ADDR_W are ignored, so a full-size part of 18 address bits is the same design with a larger parameter.

Top module: `spi_flash_resp`

## Requirements
- R1: `mosi` is sampled MSB first on each rising `sck` edge while `cs_n` is low, and `miso` changes after falling `sck` edges. `cs_n` high restarts framing at the opcode, and `miso` is 0 whenever `cs_n` has been high for a cycle or no read data is being returned.
- R2: Opcode 03h followed by a 3-byte address returns array bytes from that address onward, advancing by one per byte and wrapping at the array end. Address bits at and above ADDR_W are ignored.
- R3: Opcode 0Bh behaves like 03h but inserts one ignored dummy byte after the address before the first data byte.
- R4: Opcode 06h sets the write-enable latch and 04h clears it. The latch also clears when a program, write or erase job finishes. A program or write that is not executed leaves the latch unchanged.
- R5: Opcodes 02h, 0Ah, DBh and D8h are ignored unless the write-enable latch is set when their opcode arrives.
- R6: Opcode 05h returns a status byte with bit 1 = write-enable latch and bit 0 = busy, repeated for as long as it is clocked. While busy, every other opcode is ignored and returns 0 data.
- R7: Page program 02h ANDs each received byte into the array. Page write 0Ah sets every byte of the page to FFh except the received bytes, which it stores. Data bytes wrap within the 256-byte page. Either opcode executes only if `cs_n` rises on a byte boundary after at least one data byte.
- R8: Page erase DBh sets the addressed 256-byte page to FFh, and sector erase D8h sets the addressed 2^SECT_W-byte sector to FFh. Each executes only if `cs_n` rises right after the third address byte.
- R9: While `wp_n` is low when `cs_n` rises, any program, write or erase whose target page or sector starts below PROT_PAGES*256 is not executed.
- R10: Opcode B9h enters power-down. There every opcode except ABh is ignored, including 05h and 06h, and ABh leaves power-down. B9h issued while busy is ignored.
- R11: Opcode 9Fh returns 20h, 40h, 12h, then 00h for further bytes.
- R12: After reset the write-enable latch, busy flag and power-down state are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low protect pin for the lowest pages |
| miso | output | 1 | Serial data out of the block |

## Verification
The properties assume that `sck`, `cs_n`, `mosi` and `wp_n` are synchronous to `clk` and stay stable for several `clk` cycles around each serial edge. They also assume that `cs_n` changes only while `sck` is low. The bench drives every serial input on the falling edge of `clk` and holds each `sck` level for four cycles. It lowers `sck` before raising `cs_n`, and it changes `wp_n` only between transactions, so each rise, fall and select edge is seen exactly once.

// File: rtl/spi_flash_resp.sv
module spi_flash_resp #(
  parameter int ADDR_W     = 11,
  parameter int SECT_W     = 10,
  parameter int PROT_PAGES = 2,
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h4012
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int PG_W     = 8;
  localparam int PG       = 1 << PG_W;
  localparam int MEM      = 1 << ADDR_W;
  localparam int PROT_LIM = PROT_PAGES * PG;
  localparam logic [ADDR_W-1:0] PMASK = ~ADDR_W'(PG - 1);
  localparam logic [ADDR_W-1:0] SMASK = ~ADDR_W'((1 << SECT_W) - 1);

  localparam logic [7:0] OP_READ = 8'h03, OP_FREAD = 8'h0B, OP_PP = 8'h02,
    OP_PW = 8'h0A, OP_PE = 8'hDB, OP_SE = 8'hD8, OP_WREN = 8'h06,
    OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_RDID = 8'h9F, OP_DP = 8'hB9,
    OP_RDP = 8'hAB;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DIN, PH_DOUT, PH_END, PH_IGN} ph_t;

  logic              sck_q, cs_q;
  logic [2:0]        bcnt;
  logic [6:0]        shin;
  ph_t               ph;
  logic [7:0]        opc, xop, tx, nxt;
  logic [1:0]        nab, idn;
  logic [ADDR_W-1:0] aw, rptr, base;
  logic [PG_W-1:0]   col;
  logic              got, wel, busy, dpd;
  logic [SECT_W-1:0] ocnt;
  logic [PG-1:0]     pv;
  logic [7:0]        mem  [MEM];
  logic [7:0]        pbuf [PG];

  wire        rise  = sck & ~sck_q & ~cs_n;
  wire        fall  = ~sck & sck_q & ~cs_n;
  wire [7:0]  rxb   = {shin, mosi};
  wire        bdone = rise && (bcnt == 3'd7);
  wire [ADDR_W-1:0] anew = ADDR_W'({aw, rxb});

  wire is_wr  = (rxb == OP_PP) || (rxb == OP_PW) || (rxb == OP_PE) || (rxb == OP_SE);
  wire is_ad  = is_wr || (rxb == OP_READ) || (rxb == OP_FREAD);
  wire is_out = (rxb == OP_RDSR) || (rxb == OP_RDID);
  wire is_end = (rxb == OP_WREN) || (rxb == OP_WRDI) || (rxb == OP_DP) || (rxb == OP_RDP);
  wire cmd_ok = dpd  ? (rxb == OP_RDP) :
                busy ? (rxb == OP_RDSR) :
                is_wr ? wel : (is_ad || is_out || is_end);

  wire [ADDR_W-1:0] tgt  = (opc == OP_SE) ? (aw & SMASK) : (aw & PMASK);
  wire              prot = !wp_n && (32'(tgt) < PROT_LIM);

  wire [SECT_W-1:0] olast = (xop == OP_SE) ? '1 : SECT_W'(PG - 1);
  wire [ADDR_W-1:0] waddr = base | ADDR_W'(ocnt);
  wire [PG_W-1:0]   wcol  = ocnt[PG_W-1:0];
  wire [7:0]        wdata = (xop == OP_PP) ? (mem[waddr] & (pv[wcol] ? pbuf[wcol] : 8'hFF)) :
                            (xop == OP_PW && pv[wcol]) ? pbuf[wcol] : 8'hFF;

  assign miso = tx[7];

  always_comb begin
    nxt = 8'h00;
    if (ph == PH_DOUT)
      case (opc)
        OP_RDSR:  nxt = {6'b0, wel, busy};
        OP_RDID:  nxt = (idn == 2'd0) ? MFR_ID : (idn == 2'd1) ? DEV_ID[15:8] :
                        (idn == 2'd2) ? DEV_ID[7:0] : 8'h00;
        OP_READ, OP_FREAD: nxt = mem[rptr];
        default:  nxt = 8'h00;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bcnt <= '0; shin <= '0; ph <= PH_CMD;
      opc <= '0; xop <= '0; tx <= '0; nab <= '0; idn <= '0; aw <= '0;
      rptr <= '0; base <= '0; col <= '0; got <= 1'b0; wel <= 1'b0;
      busy <= 1'b0; dpd <= 1'b0; ocnt <= '0; pv <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (busy) begin
        ocnt <= ocnt + 1'b1;
        if (ocnt == olast) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end
      if (cs_n) begin
        ph <= PH_CMD; bcnt <= '0; nab <= '0; got <= 1'b0; idn <= '0; tx <= '0;
        if (!cs_q && bcnt == 3'd0) begin
          if (ph == PH_END)
            case (opc)
              OP_WREN: wel <= 1'b1;
              OP_WRDI: wel <= 1'b0;
              OP_DP:   dpd <= 1'b1;
              OP_RDP:  dpd <= 1'b0;
              OP_PE, OP_SE:
                if (!prot) begin
                  busy <= 1'b1; xop <= opc; base <= tgt; ocnt <= '0;
                end
              default: ;
            endcase
          else if (ph == PH_DIN && got && !prot) begin
            busy <= 1'b1; xop <= opc; base <= tgt; ocnt <= '0;
          end
        end
      end else begin
        if (rise) begin
          bcnt <= bcnt + 1'b1;
          shin <= rxb[6:0];
        end
        if (bdone)
          case (ph)
            PH_CMD: begin
              opc <= rxb;
              if (!cmd_ok)     ph <= PH_IGN;
              else if (is_ad)  ph <= PH_ADDR;
              else if (is_out) ph <= PH_DOUT;
              else             ph <= PH_END;
              if (cmd_ok && (rxb == OP_PP || rxb == OP_PW)) pv <= '0;
            end
            PH_ADDR: begin
              aw  <= anew;
              nab <= nab + 1'b1;
              if (nab == 2'd2) begin
                rptr <= anew;
                col  <= anew[PG_W-1:0];
                case (opc)
                  OP_READ:      ph <= PH_DOUT;
                  OP_FREAD:     ph <= PH_DUMMY;
                  OP_PP, OP_PW: ph <= PH_DIN;
                  default:      ph <= PH_END;
                endcase
              end
            end
            PH_DUMMY: ph <= PH_DOUT;
            PH_DIN: begin
              pv[col] <= 1'b1;
              col     <= col + 1'b1;
              got     <= 1'b1;
            end
            PH_END:  ph <= PH_IGN;
            default: ;
          endcase
        if (fall) begin
          if (bcnt == 3'd0) begin
            tx <= nxt;
            if (ph == PH_DOUT) begin
              rptr <= rptr + 1'b1;
              if (idn != 2'd3) idn <= idn + 1'b1;
            end
          end else
            tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (!cs_n && bdone && ph == PH_DIN) pbuf[col] <= rxb;

  always_ff @(posedge clk)
    if (busy) mem[waddr] <= wdata;

endmodule

// File: rtl/spi_flash_resp_chk.sv
module spi_flash_resp_chk #(
  parameter int ADDR_W     = 11,
  parameter int PROT_PAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic              wp_n,
  input logic              wel,
  input logic              busy,
  input logic              dpd,
  input logic [ADDR_W-1:0] base
);
  localparam int PROT_LIM = PROT_PAGES * 256;

  p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso);

  p_start_needs_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  p_done_drops_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_sleep_never_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> !busy);

  p_guard_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(wp_n)) |-> (32'(base) >= PROT_LIM));
endmodule

bind spi_flash_resp spi_flash_resp_chk #(.ADDR_W(ADDR_W), .PROT_PAGES(PROT_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .wp_n(wp_n),
  .wel(wel), .busy(busy), .dpd(dpd), .base(base)
);

// File: tb/sim_spi_flash_resp.sv
module sim_spi_flash_resp;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  wire  miso;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] txq [10];
  logic [7:0] rxq [10];
  logic [7:0] s, d;

  always #4 clk = ~clk;

  spi_flash_resp u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                     .mosi(mosi), .wp_n(wp_n), .miso(miso));

  // address, programmed byte, expected readback
  localparam logic [26:0] VEC [5] = '{
    {11'h300, 8'hF0, 8'hF0},
    {11'h300, 8'h3C, 8'h30},
    {11'h301, 8'hA5, 8'hA5},
    {11'h3FF, 8'h5A, 8'h5A},
    {11'h300, 8'hFF, 8'h30}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input int extra);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        mosi = txq[b][i]; sck = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1; rxq[b][i] = miso;
        repeat (4) @(negedge clk);
      end
    for (int i = 0; i < extra; i++) begin
      mosi = 1'b1; sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    txq[0] = op; run(1, 0);
  endtask

  task automatic status(output logic [7:0] st);
    txq[0] = 8'h05; txq[1] = 8'h00; run(2, 0); st = rxq[1];
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    for (int k = 0; k < 100; k++) begin
      status(st);
      if (!st[0]) break;
    end
  endtask

  task automatic acmd(input logic [7:0] op, input logic [23:0] a, input int nd, input int extra);
    txq[0] = op; txq[1] = a[23:16]; txq[2] = a[15:8]; txq[3] = a[7:0];
    run(4 + nd, extra);
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] v);
    txq[4] = 8'h00; acmd(8'h03, a, 1, 0); v = rxq[4];
  endtask

  task automatic pp1(input logic [7:0] op, input logic [23:0] a, input logic [7:0] v);
    txq[4] = v; acmd(op, a, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 miso after reset", {7'b0, miso}, 8'h00);
    status(s); chk("R12 status after reset", s, 8'h00);

    txq[1] = 0; txq[2] = 0; txq[3] = 0; txq[4] = 0; op1(8'h9F);
    txq[0] = 8'h9F; run(5, 0);
    chk("R11 id byte0", rxq[1], 8'h20);
    chk("R11 id byte1", rxq[2], 8'h40);
    chk("R11 id byte2", rxq[3], 8'h12);
    chk("R11 id tail", rxq[4], 8'h00);

    op1(8'h06); status(s); chk("R4 latch set", s, 8'h02);
    op1(8'h04); status(s); chk("R4 latch cleared", s, 8'h00);

    // erase both sectors; probe busy behaviour during the first
    op1(8'h06); acmd(8'hD8, 24'h000000, 0, 0);
    status(s); chk("R6 status while busy", s, 8'h03);
    txq[4] = 0; txq[5] = 0; acmd(8'h03, 24'h000010, 2, 0);
    chk("R6 read ignored while busy", rxq[4], 8'h00);
    op1(8'hB9);
    wait_ready();
    status(s); chk("R4 latch cleared at finish", s, 8'h00);
    txq[1] = 0; txq[0] = 8'h9F; run(2, 0);
    chk("R10 power-down refused while busy", rxq[1], 8'h20);
    op1(8'h06); acmd(8'hD8, 24'h000400, 0, 0); wait_ready();
    rd(24'h000000, d); chk("R8 sector0 erased", d, 8'hFF);
    rd(24'h0007FF, d); chk("R8 sector1 erased", d, 8'hFF);

    for (int v = 0; v < 5; v++) begin
      op1(8'h06);
      pp1(8'h02, {13'b0, VEC[v][26:16]}, VEC[v][15:8]);
      wait_ready();
      rd({13'b0, VEC[v][26:16]}, d);
      chk($sformatf("R7 program vector %0d", v), d, VEC[v][7:0]);
    end

    pp1(8'h02, 24'h000301, 8'h00); wait_ready();
    rd(24'h000301, d); chk("R5 program without latch", d, 8'hA5);

    op1(8'h06); pp1(8'h0A, 24'h000305, 8'h12); wait_ready();
    rd(24'h000305, d); chk("R7 page write stored", d, 8'h12);
    rd(24'h000300, d); chk("R7 page write erased rest", d, 8'hFF);
    rd(24'h000301, d); chk("R7 page write erased rest2", d, 8'hFF);

    op1(8'h06); txq[4] = 8'hAA; txq[5] = 8'hBB; acmd(8'h02, 24'h0006FF, 2, 0); wait_ready();
    txq[4] = 0; txq[5] = 0; acmd(8'h03, 24'h0006FF, 2, 0);
    chk("R2 read first", rxq[4], 8'hAA);
    chk("R7 no spill to next page", rxq[5], 8'hFF);
    rd(24'h000600, d); chk("R7 wrap inside page", d, 8'hBB);
    rd(24'hFFF6FF, d); chk("R2 upper address bits ignored", d, 8'hAA);
    txq[4] = 8'h55; txq[5] = 0; acmd(8'h0B, 24'h0006FF, 2, 0);
    chk("R3 fast read after dummy", rxq[5], 8'hAA);

    op1(8'h06); txq[4] = 8'h00; acmd(8'h02, 24'h000650, 1, 3); wait_ready();
    rd(24'h000650, d); chk("R7 partial byte discarded", d, 8'hFF);
    status(s); chk("R4 latch kept after discard", s, 8'h02);
    acmd(8'h02, 24'h000650, 0, 0); wait_ready();
    status(s); chk("R7 no data bytes discarded", s, 8'h02);
    op1(8'h04);

    op1(8'h06); acmd(8'hDB, 24'h000623, 0, 0); wait_ready();
    rd(24'h0006FF, d); chk("R8 page erase end", d, 8'hFF);
    rd(24'h000600, d); chk("R8 page erase start", d, 8'hFF);
    rd(24'h000305, d); chk("R8 other page kept", d, 8'h12);

    wp_n = 1'b0;
    op1(8'h06); pp1(8'h02, 24'h000100, 8'h00); wait_ready();
    rd(24'h000100, d); chk("R9 protected page unchanged", d, 8'hFF);
    pp1(8'h02, 24'h000200, 8'h11); wait_ready();
    rd(24'h000200, d); chk("R9 page above limit programmed", d, 8'h11);
    op1(8'h06); acmd(8'hD8, 24'h000000, 0, 0); wait_ready();
    rd(24'h000200, d); chk("R9 sector erase refused", d, 8'h11);
    op1(8'h04); wp_n = 1'b1;

    op1(8'hB9);
    txq[1] = 0; txq[0] = 8'h9F; run(2, 0); chk("R10 id ignored in power-down", rxq[1], 8'h00);
    status(s); chk("R10 status ignored in power-down", s, 8'h00);
    op1(8'h06);
    op1(8'hAB);
    status(s); chk("R10 latch set ignored in power-down", s, 8'h00);
    txq[1] = 0; txq[0] = 8'h9F; run(2, 0); chk("R10 release restores id", rxq[1], 8'h20);
    chk("R1 miso idle at end", {7'b0, miso}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule